// File: doc/BRIEF.md
# NAND Power-On Bring-Up and Identification Controller

This block takes a freshly powered NAND flash device to a known, described state without help from software. On a start pulse it drives the flash's 8-bit command/address/data bus. It sends a reset command and waits a fixed settling time. It then polls the status register until the device shows ready, and reads the five-byte identification string. The first two identification bytes are matched against a built-in table of supported parts, and the fourth byte is decoded into page, spare area, block and bus-width geometry.

Each bus operation uses a parameterised number of clock cycles: the strobe is low for all but the last cycle. Every delay comes from a clock-frequency parameter, so a faster or slower system clock only changes that parameter. The result is a done flag with a 2-bit result code and the decoded geometry, all held until the next start pulse.

Top module: `nand_init_top`

## Requirements
- R1: After reset, done is 0, errCode is 0, every geometry output is 0, nandWeN and nandReN are 1, and nandCle, nandAle and nandDoutEn are 0.
- R2: Each bus operation lasts STROBE_CYCLES clocks, with its strobe low for the first STROBE_CYCLES-1 of them. A command operation holds nandCle high and an address operation holds nandAle high, both with write data driven. nandWeN and nandReN are never low together.
- R3: A start pulse issues command 0xFF. The first read-status command 0x70 does not begin until at least CLK_HZ/1000 clocks after the reset command ends.
- R4: The device counts as ready only when bits 5 and 6 of a status byte are both 1. A status byte with only one of them set, or with neither, leads to another status command and read.
- R5: With extVerify at 1, each not-ready poll waits a further CLK_HZ/20000 clocks before the next status command. After POLL_LIMIT+1 not-ready status reads the run ends with errCode 1 and no identification command. With extVerify at 0 polling continues back to back with no limit.
- R6: After ready, the block sends command 0x90, then one address cycle of 0x00, then exactly five data reads.
- R7: If ID byte 0 is not 0x2C or ID byte 1 is not 0xBA, the run ends with errCode 2 and all geometry outputs stay 0.
- R8: ID byte 3 is decoded as follows. Bits 1:0 give the page size, 1024 bytes shifted left by the code. Bit 2 gives the spare bytes per 512 data bytes, 8 when 0 and 16 when 1. Bits 5:4 give the block size, 65536 bytes shifted left by the code. Bit 6 is 1 for a 16-bit bus. Bit 7 has no effect.
- R9: A matched part ends with errCode 0 only when it has a 2048-byte page, a 64-byte spare area and a 131072-byte block; any other matched geometry ends with errCode 3. The bus width does not affect the code.
- R10: For a matched part (errCode 0 or 3), the block loads the decoded geometry and the part's address shifts (block 17, page 11). It also loads pagesPerBlock, equal to block size divided by page size, which is 64 for the supported part.
- R11: done rises when a run ends and stays 1, with errCode and the geometry unchanged, until the next start pulse. That pulse clears done, errCode and the geometry on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins bring-up when idle |
| extVerify | input | 1 | 1 = bounded, paced status polling |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandDout | output | 8 | Byte driven toward the flash |
| nandDoutEn | output | 1 | 1 while nandDout should drive the bus |
| nandDin | input | 8 | Byte returned by the flash |
| done | output | 1 | Run finished; held until next start |
| errCode | output | 2 | 0 ok, 1 timeout, 2 part not found, 3 geometry unsupported |
| pageBytes | output | 14 | Decoded page size in bytes |
| spareBytes | output | 9 | Decoded spare area per page in bytes |
| blockBytes | output | 20 | Decoded block size in bytes |
| pagesPerBlock | output | 10 | Block size divided by page size |
| busWide | output | 1 | 1 = 16-bit device organisation |
| blockShift | output | 5 | Block-address shift of the matched part |
| pageShift | output | 5 | Page-address shift of the matched part |

## Verification
The fourth ID byte is swept over all 256 values, which separates each decoded field, the bit that must be ignored and the single accepted geometry from every near miss. Status sequences that set only bit 5, only bit 6 or neither before becoming ready test the two-bit ready rule. These sequences run with and without extended verification, and the spacing between status commands distinguishes paced polling from back-to-back polling. A device that never becomes ready shows the poll bound. Mismatched manufacturer and device codes, including a swapped pair, test the table lookup.

// File: rtl/nand_init_pkg.sv
package nand_init_pkg;

  localparam int PAGE_W  = 14;
  localparam int SPARE_W = 9;
  localparam int BLOCK_W = 20;
  localparam int PPB_W   = 10;
  localparam int SHIFT_W = 5;

  localparam logic [7:0] CMD_RESET  = 8'hFF;
  localparam logic [7:0] CMD_STATUS = 8'h70;
  localparam logic [7:0] CMD_READID = 8'h90;
  localparam logic [7:0] ID_ADDR    = 8'h00;

  typedef enum logic [1:0] {
    OP_CMD  = 2'd0,
    OP_ADDR = 2'd1,
    OP_READ = 2'd2
  } busOp_e;

  typedef enum logic [1:0] {
    RES_OK       = 2'd0,
    RES_TIMEOUT  = 2'd1,
    RES_NOTFOUND = 2'd2,
    RES_GEOM     = 2'd3
  } result_e;

  typedef struct packed {
    logic    opGo;
    busOp_e  opKind;
    logic [7:0] opByte;
    logic    capStatus;
    logic    capId;
    logic [2:0] idIdx;
    logic    clrResult;
    logic    finish;
    result_e finishCode;
  } ctrlStrb_t;

  typedef struct packed {
    logic [7:0] mfr;
    logic [7:0] dev;
    logic [SHIFT_W-1:0] blkShift;
    logic [SHIFT_W-1:0] pgShift;
  } partEntry_t;

  localparam int NUM_PARTS = 1;
  localparam partEntry_t PART_TABLE [NUM_PARTS] = '{
    '{mfr: 8'h2C, dev: 8'hBA, blkShift: 5'd17, pgShift: 5'd11}
  };

endpackage

// File: rtl/nand_init_ctrl.sv
module nand_init_ctrl
  import nand_init_pkg::*;
#(
  parameter int RESET_WAIT = 100000,
  parameter int POLL_WAIT  = 5000,
  parameter int POLL_LIMIT = 20000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      extVerify,
  input  logic      opDone,
  input  logic      statusReady,
  input  logic      idMatch,
  input  logic      geomOk,
  output ctrlStrb_t strb
);

  localparam int WAIT_MAX = (RESET_WAIT > POLL_WAIT) ? RESET_WAIT : POLL_WAIT;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int POLL_W   = $clog2(POLL_LIMIT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RST_CMD, S_RST_WAIT, S_STAT_CMD, S_STAT_RD, S_STAT_CHK,
    S_POLL_WAIT, S_ID_CMD, S_ID_ADDR, S_ID_RD, S_EVAL
  } state_e;

  state_e state;
  logic [WAIT_W-1:0] waitCnt;
  logic [POLL_W-1:0] pollCnt;
  logic [2:0] idCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
      pollCnt <= '0;
      idCnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) state <= S_RST_CMD;
        S_RST_CMD: if (opDone) begin
          waitCnt <= WAIT_W'(RESET_WAIT - 1);
          pollCnt <= '0;
          state   <= S_RST_WAIT;
        end
        S_RST_WAIT: begin
          if (waitCnt == '0) state <= S_STAT_CMD;
          else waitCnt <= waitCnt - 1'b1;
        end
        S_STAT_CMD: if (opDone) state <= S_STAT_RD;
        S_STAT_RD:  if (opDone) state <= S_STAT_CHK;
        S_STAT_CHK: begin
          if (statusReady) state <= S_ID_CMD;
          else if (extVerify) begin
            if (pollCnt == POLL_W'(POLL_LIMIT)) state <= S_IDLE;
            else begin
              pollCnt <= pollCnt + 1'b1;
              waitCnt <= WAIT_W'(POLL_WAIT - 1);
              state   <= S_POLL_WAIT;
            end
          end else state <= S_STAT_CMD;
        end
        S_POLL_WAIT: begin
          if (waitCnt == '0) state <= S_STAT_CMD;
          else waitCnt <= waitCnt - 1'b1;
        end
        S_ID_CMD: if (opDone) state <= S_ID_ADDR;
        S_ID_ADDR: if (opDone) begin
          idCnt <= '0;
          state <= S_ID_RD;
        end
        S_ID_RD: if (opDone) begin
          if (idCnt == 3'd4) state <= S_EVAL;
          else idCnt <= idCnt + 1'b1;
        end
        S_EVAL: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb = '0;
    strb.opKind = OP_CMD;
    strb.finishCode = RES_OK;
    strb.idIdx = idCnt;
    case (state)
      S_IDLE: strb.clrResult = start;
      S_RST_CMD: begin
        strb.opGo = 1'b1; strb.opByte = CMD_RESET;
      end
      S_STAT_CMD: begin
        strb.opGo = 1'b1; strb.opByte = CMD_STATUS;
      end
      S_STAT_RD: begin
        strb.opGo = 1'b1; strb.opKind = OP_READ; strb.capStatus = opDone;
      end
      S_STAT_CHK: begin
        if (!statusReady && extVerify && pollCnt == POLL_W'(POLL_LIMIT)) begin
          strb.finish = 1'b1; strb.finishCode = RES_TIMEOUT;
        end
      end
      S_ID_CMD: begin
        strb.opGo = 1'b1; strb.opByte = CMD_READID;
      end
      S_ID_ADDR: begin
        strb.opGo = 1'b1; strb.opKind = OP_ADDR; strb.opByte = ID_ADDR;
      end
      S_ID_RD: begin
        strb.opGo = 1'b1; strb.opKind = OP_READ; strb.capId = opDone;
      end
      S_EVAL: begin
        strb.finish = 1'b1;
        strb.finishCode = !idMatch ? RES_NOTFOUND : (!geomOk ? RES_GEOM : RES_OK);
      end
      default: ;
    endcase
  end

  // R5: the poll counter never passes its bound
  a_r5_poll_bound: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt <= POLL_W'(POLL_LIMIT));

  // R5: a timeout result is only reachable in extended-verify mode
  a_r5_timeout_needs_ext: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && strb.finishCode == RES_TIMEOUT) |-> extVerify);

  // R6: identification reads follow the address cycle
  a_r6_id_order: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ID_RD && $past(state) != S_ID_RD) |-> $past(state) == S_ID_ADDR);

endmodule

// File: rtl/nand_init_dp.sv
module nand_init_dp
  import nand_init_pkg::*;
#(
  parameter int STROBE_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  ctrlStrb_t strb,
  output logic opDone,
  output logic statusReady,
  output logic idMatch,
  output logic geomOk,
  output logic nandCle,
  output logic nandAle,
  output logic nandWeN,
  output logic nandReN,
  output logic [7:0] nandDout,
  output logic nandDoutEn,
  input  logic [7:0] nandDin,
  output logic done,
  output logic [1:0] errCode,
  output logic [PAGE_W-1:0]  pageBytes,
  output logic [SPARE_W-1:0] spareBytes,
  output logic [BLOCK_W-1:0] blockBytes,
  output logic [PPB_W-1:0]   pagesPerBlock,
  output logic busWide,
  output logic [SHIFT_W-1:0] blockShift,
  output logic [SHIFT_W-1:0] pageShift
);

  localparam int CNT_W = (STROBE_CYCLES > 2) ? $clog2(STROBE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(STROBE_CYCLES - 1);
  localparam logic [CNT_W-1:0] SAMPLE = CNT_W'(STROBE_CYCLES - 2);

  // bus operation engine
  logic busy;
  logic [CNT_W-1:0] cnt;
  busOp_e kind;
  logic [7:0] outByte;
  logic [7:0] rdByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; cnt <= '0; kind <= OP_CMD; outByte <= '0; rdByte <= '0;
    end else begin
      if (!busy && strb.opGo) begin
        busy <= 1'b1; cnt <= '0; kind <= strb.opKind; outByte <= strb.opByte;
      end else if (busy) begin
        if (kind == OP_READ && cnt == SAMPLE) rdByte <= nandDin;
        if (cnt == LAST) busy <= 1'b0;
        else cnt <= cnt + 1'b1;
      end
    end
  end

  assign opDone     = busy && cnt == LAST;
  assign nandCle    = busy && kind == OP_CMD;
  assign nandAle    = busy && kind == OP_ADDR;
  assign nandDoutEn = busy && kind != OP_READ;
  assign nandDout   = outByte;
  assign nandWeN    = !(busy && kind != OP_READ && cnt != LAST);
  assign nandReN    = !(busy && kind == OP_READ && cnt != LAST);

  // captured status and identification bytes
  logic [7:0] idMfr, idDev;
  logic [6:0] idGeo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusReady <= 1'b0; idMfr <= '0; idDev <= '0; idGeo <= '0;
    end else begin
      if (strb.clrResult) statusReady <= 1'b0;
      else if (strb.capStatus) statusReady <= rdByte[5] & rdByte[6];
      if (strb.capId) begin
        case (strb.idIdx)
          3'd0: idMfr <= rdByte;
          3'd1: idDev <= rdByte;
          3'd3: idGeo <= rdByte[6:0];
          default: ;
        endcase
      end
    end
  end

  // part table lookup, lowest index wins
  logic [NUM_PARTS-1:0] hitVec;
  logic [SHIFT_W-1:0] hitBlk, hitPg;

  for (genvar g = 0; g < NUM_PARTS; g++) begin : g_part
    assign hitVec[g] = (idMfr == PART_TABLE[g].mfr) && (idDev == PART_TABLE[g].dev);
  end

  always_comb begin
    hitBlk = '0;
    hitPg  = '0;
    for (int k = NUM_PARTS - 1; k >= 0; k--) begin
      if (hitVec[k]) begin
        hitBlk = PART_TABLE[k].blkShift;
        hitPg  = PART_TABLE[k].pgShift;
      end
    end
  end

  assign idMatch = |hitVec;

  // geometry decode of the fourth identification byte
  logic [1:0] pgCode, blkCode;
  logic spareBit;
  logic [PAGE_W-1:0]  decPage;
  logic [SPARE_W-1:0] decSpare;
  logic [BLOCK_W-1:0] decBlock;
  logic [PPB_W-1:0]   decPpb;

  always_comb begin
    pgCode   = idGeo[1:0];
    spareBit = idGeo[2];
    blkCode  = idGeo[5:4];
    decPage  = PAGE_W'(1024) << pgCode;
    decSpare = SPARE_W'(16) << ({1'b0, pgCode} + {2'b00, spareBit});
    decBlock = BLOCK_W'(65536) << blkCode;
    decPpb   = (PPB_W'(64) << blkCode) >> pgCode;
  end

  assign geomOk = (pgCode == 2'd1) && spareBit && (blkCode == 2'd1);

  // result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done <= 1'b0; errCode <= '0;
      pageBytes <= '0; spareBytes <= '0; blockBytes <= '0; pagesPerBlock <= '0;
      busWide <= 1'b0; blockShift <= '0; pageShift <= '0;
    end else if (strb.clrResult) begin
      done <= 1'b0; errCode <= '0;
      pageBytes <= '0; spareBytes <= '0; blockBytes <= '0; pagesPerBlock <= '0;
      busWide <= 1'b0; blockShift <= '0; pageShift <= '0;
    end else if (strb.finish) begin
      done <= 1'b1;
      errCode <= strb.finishCode;
      if (idMatch && strb.finishCode != RES_TIMEOUT) begin
        pageBytes <= decPage; spareBytes <= decSpare; blockBytes <= decBlock;
        pagesPerBlock <= decPpb; busWide <= idGeo[6];
        blockShift <= hitBlk; pageShift <= hitPg;
      end
    end
  end

  // R2: read and write strobes never overlap
  a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));

  // R2: latch enables only accompany driven write data
  a_r2_latch_write: assert property (@(posedge clk) disable iff (!rstN)
    (nandCle || nandAle) |-> nandDoutEn);

  // R11: a finished result holds until a start clears it
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (done && !strb.clrResult) |=> (done && $stable(errCode) && $stable(pageBytes)));

  // R11: start clears the result on the next clock
  a_r11_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrResult |=> !done);

  // R7: an unmatched part leaves the geometry empty
  a_r7_zero_geom: assert property (@(posedge clk) disable iff (!rstN)
    (done && errCode == RES_NOTFOUND) |-> (pageBytes == '0 && blockShift == '0));

endmodule

// File: rtl/nand_init_top.sv
module nand_init_top
  import nand_init_pkg::*;
#(
  parameter int CLK_HZ        = 100000000,
  parameter int STROBE_CYCLES = 4,
  parameter int POLL_LIMIT    = 20000
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic extVerify,
  output logic nandCle,
  output logic nandAle,
  output logic nandWeN,
  output logic nandReN,
  output logic [7:0] nandDout,
  output logic nandDoutEn,
  input  logic [7:0] nandDin,
  output logic done,
  output logic [1:0] errCode,
  output logic [13:0] pageBytes,
  output logic [8:0] spareBytes,
  output logic [19:0] blockBytes,
  output logic [9:0] pagesPerBlock,
  output logic busWide,
  output logic [4:0] blockShift,
  output logic [4:0] pageShift
);

  localparam int RESET_WAIT = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
  localparam int POLL_WAIT  = (CLK_HZ / 20000 > 0) ? CLK_HZ / 20000 : 1;

  ctrlStrb_t strb;
  logic opDone, statusReady, idMatch, geomOk;

  nand_init_ctrl #(
    .RESET_WAIT(RESET_WAIT),
    .POLL_WAIT (POLL_WAIT),
    .POLL_LIMIT(POLL_LIMIT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .extVerify(extVerify),
    .opDone(opDone), .statusReady(statusReady), .idMatch(idMatch),
    .geomOk(geomOk), .strb(strb)
  );

  nand_init_dp #(
    .STROBE_CYCLES(STROBE_CYCLES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .opDone(opDone), .statusReady(statusReady), .idMatch(idMatch), .geomOk(geomOk),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN),
    .nandDout(nandDout), .nandDoutEn(nandDoutEn), .nandDin(nandDin),
    .done(done), .errCode(errCode), .pageBytes(pageBytes), .spareBytes(spareBytes),
    .blockBytes(blockBytes), .pagesPerBlock(pagesPerBlock), .busWide(busWide),
    .blockShift(blockShift), .pageShift(pageShift)
  );

endmodule

// File: tb/nand_init_top_tb_top.sv
module nand_init_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 100000;
  localparam int STROBE     = 4;
  localparam int POLL_LIMIT = 6;
  localparam int RST_WAIT   = CLK_HZ / 1000;
  localparam int POLL_GAP   = CLK_HZ / 20000;
  localparam int NEVER      = 1000000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic extVerify = 1'b0;
  logic nandCle, nandAle, nandWeN, nandReN, nandDoutEn;
  logic [7:0] nandDout;
  logic [7:0] nandDin;
  logic done, busWide;
  logic [1:0] errCode;
  logic [13:0] pageBytes;
  logic [8:0] spareBytes;
  logic [19:0] blockBytes;
  logic [9:0] pagesPerBlock;
  logic [4:0] blockShift, pageShift;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nand_init_top #(
    .CLK_HZ(CLK_HZ), .STROBE_CYCLES(STROBE), .POLL_LIMIT(POLL_LIMIT)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .extVerify(extVerify),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN),
    .nandDout(nandDout), .nandDoutEn(nandDoutEn), .nandDin(nandDin),
    .done(done), .errCode(errCode), .pageBytes(pageBytes), .spareBytes(spareBytes),
    .blockBytes(blockBytes), .pagesPerBlock(pagesPerBlock), .busWide(busWide),
    .blockShift(blockShift), .pageShift(pageShift)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // flash model state
  int rdyAfter = 0;
  logic [7:0] idB [5];
  logic [7:0] curCmd = 8'h00;
  int nRst, nStatCmd, nStatRd, nIdCmd, nAddr, nIdRd, overlapErr, widthErr;
  int rstEndCyc, firstStatCyc, statPrev, statLast;
  logic [7:0] lastAddr;
  logic prevWeN = 1'b1, prevReN = 1'b1;
  int weLow = 0;

  function automatic logic [7:0] statusVal(int i);
    if (i < rdyAfter) begin
      case (i % 3)
        0: return 8'h20;
        1: return 8'h40;
        default: return 8'h9F;
      endcase
    end
    return ((i % 2) == 1) ? 8'hE1 : 8'h60;
  endfunction

  always_comb begin
    if (curCmd == 8'h70) nandDin = statusVal(nStatRd);
    else if (curCmd == 8'h90 && nIdRd < 5) nandDin = idB[nIdRd];
    else nandDin = 8'h00;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!nandWeN && !nandReN) overlapErr = overlapErr + 1;
    if (!nandWeN) weLow = weLow + 1;
    if (prevWeN && !nandWeN && nandCle && nandDout == 8'h70) begin
      if (firstStatCyc < 0) firstStatCyc = cyc;
      statPrev = statLast;
      statLast = cyc;
    end
    if (!prevWeN && nandWeN) begin
      if (weLow != STROBE - 1) widthErr = widthErr + 1;
      weLow = 0;
      if (nandCle) begin
        curCmd = nandDout;
        if (nandDout == 8'hFF) begin nRst = nRst + 1; rstEndCyc = cyc; end
        if (nandDout == 8'h70) nStatCmd = nStatCmd + 1;
        if (nandDout == 8'h90) nIdCmd = nIdCmd + 1;
      end
      if (nandAle) begin nAddr = nAddr + 1; lastAddr = nandDout; end
    end
    if (!prevReN && nandReN) begin
      if (curCmd == 8'h70) nStatRd = nStatRd + 1;
      else if (curCmd == 8'h90) nIdRd = nIdRd + 1;
    end
    prevWeN = nandWeN;
    prevReN = nandReN;
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runOnce(input logic [7:0] mfr, input logic [7:0] dev,
                         input logic [7:0] geo, input logic ext, input int ready);
    @(negedge clk);
    idB[0] = mfr; idB[1] = dev; idB[2] = 8'h01; idB[3] = geo; idB[4] = 8'h44;
    rdyAfter = ready;
    curCmd = 8'h00;
    nRst = 0; nStatCmd = 0; nStatRd = 0; nIdCmd = 0; nAddr = 0; nIdRd = 0;
    rstEndCyc = -1; firstStatCyc = -1; statPrev = -1; statLast = -1;
    lastAddr = 8'hAA;
    extVerify = ext;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 20000 && !done; n++) @(negedge clk);
  endtask

  initial begin
    overlapErr = 0; widthErr = 0;
    nRst = 0; nStatCmd = 0; nStatRd = 0; nIdCmd = 0; nAddr = 0; nIdRd = 0;
    rstEndCyc = -1; firstStatCyc = -1; statPrev = -1; statLast = -1;
    for (int i = 0; i < 5; i++) idB[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(done == 0 && errCode == 0, "R1 done/err", {done, errCode}, 0);
    chk(nandWeN && nandReN && !nandCle && !nandAle && !nandDoutEn, "R1 strobes",
        {nandWeN, nandReN, nandCle, nandAle, nandDoutEn}, 5'b11000);
    chk(pageBytes == 0 && blockBytes == 0 && pagesPerBlock == 0 && blockShift == 0,
        "R1 geometry", pageBytes, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // nominal part, ready at first poll
    runOnce(8'h2C, 8'hBA, 8'h55, 1'b0, 0);
    chk(done == 1, "R11 done raised", done, 1);
    chk(errCode == 0, "R9 nominal code", errCode, 0);
    chk(nRst == 1, "R3 one reset command", nRst, 1);
    chk(firstStatCyc - rstEndCyc >= RST_WAIT && firstStatCyc - rstEndCyc <= RST_WAIT + 3,
        "R3 settle gap", firstStatCyc - rstEndCyc, RST_WAIT + 2);
    chk(nStatRd == 1, "R4 single status read", nStatRd, 1);
    chk(nIdCmd == 1 && nAddr == 1 && lastAddr == 8'h00, "R6 id cmd/addr",
        {nIdCmd, nAddr, lastAddr}, 0);
    chk(nIdRd == 5, "R6 five id reads", nIdRd, 5);
    chk(pagesPerBlock == 64, "R10 pages per block", pagesPerBlock, 64);
    chk(blockShift == 17 && pageShift == 11, "R10 shifts", {blockShift, pageShift}, {5'd17, 5'd11});
    chk(pageBytes == 2048 && spareBytes == 64 && blockBytes == 131072 && busWide == 1,
        "R8 nominal decode", pageBytes, 2048);

    // R11: hold then clear
    repeat (40) @(negedge clk);
    chk(done == 1 && errCode == 0 && pageBytes == 2048, "R11 hold", done, 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 0 && pageBytes == 0, "R11 clear on start", done, 0);
    for (int n = 0; n < 20000 && !done; n++) @(negedge clk);

    // R4: one-bit status patterns, back-to-back polling
    runOnce(8'h2C, 8'hBA, 8'h55, 1'b0, 3);
    chk(nStatRd == 4, "R4 two-bit ready rule", nStatRd, 4);
    chk(statLast - statPrev == 2 * STROBE + 3, "R5 back-to-back poll period",
        statLast - statPrev, 2 * STROBE + 3);
    chk(errCode == 0, "R4 ready then ok", errCode, 0);

    // R5: paced polling with extended verify
    runOnce(8'h2C, 8'hBA, 8'h55, 1'b1, 3);
    chk(nStatRd == 4, "R5 ext reads", nStatRd, 4);
    chk(statLast - statPrev == 2 * STROBE + 3 + POLL_GAP, "R5 paced poll period",
        statLast - statPrev, 2 * STROBE + 3 + POLL_GAP);
    chk(errCode == 0, "R5 ext ok", errCode, 0);

    // R5: never ready with extended verify
    runOnce(8'h2C, 8'hBA, 8'h55, 1'b1, NEVER);
    chk(done == 1 && errCode == 1, "R5 timeout code", errCode, 1);
    chk(nStatRd == POLL_LIMIT + 1, "R5 timeout read count", nStatRd, POLL_LIMIT + 1);
    chk(nIdCmd == 0 && pageBytes == 0, "R5 no id after timeout", nIdCmd, 0);

    // R5: no limit without extended verify
    runOnce(8'h2C, 8'hBA, 8'h55, 1'b0, POLL_LIMIT + 4);
    chk(errCode == 0 && nStatRd == POLL_LIMIT + 5, "R5 unbounded polling", nStatRd, POLL_LIMIT + 5);

    // R7: table mismatches
    runOnce(8'h2D, 8'hBA, 8'h55, 1'b0, 0);
    chk(errCode == 2 && pageBytes == 0 && blockShift == 0, "R7 wrong manufacturer", errCode, 2);
    runOnce(8'h2C, 8'hBB, 8'h55, 1'b0, 0);
    chk(errCode == 2 && pagesPerBlock == 0, "R7 wrong device", errCode, 2);
    runOnce(8'hBA, 8'h2C, 8'h55, 1'b0, 0);
    chk(errCode == 2 && spareBytes == 0, "R7 swapped pair", errCode, 2);

    // R8, R9, R10: sweep of the geometry byte
    for (int v = 0; v < 256; v++) begin
      int ePage, eSpare, eBlock, ePpb, eCode;
      logic eWide;
      logic [7:0] gb;
      gb = 8'(v);
      ePage  = 1024 << gb[1:0];
      eSpare = (8 << gb[2]) * (ePage / 512);
      eBlock = 65536 << gb[5:4];
      ePpb   = eBlock / ePage;
      eWide  = gb[6];
      eCode  = (gb[1:0] == 2'd1 && gb[2] && gb[5:4] == 2'd1) ? 0 : 3;
      runOnce(8'h2C, 8'hBA, gb, 1'b0, 0);
      chk(errCode == eCode, "R9 geometry acceptance", errCode, eCode);
      chk(pageBytes == ePage && spareBytes == eSpare && blockBytes == eBlock &&
          busWide == eWide, "R8 decode fields", {pageBytes, spareBytes, blockBytes},
          {ePage[13:0], eSpare[8:0], eBlock[19:0]});
      chk(pagesPerBlock == ePpb && blockShift == 17 && pageShift == 11,
          "R10 derived fields", pagesPerBlock, ePpb);
    end

    // R2: strobe shape over the whole run
    chk(overlapErr == 0, "R2 strobe overlap", overlapErr, 0);
    chk(widthErr == 0, "R2 write strobe width", widthErr, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 190000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule